// File: doc/BRIEF.md
# Decimated Rotary-Encoder Delay Setpoint

This block turns turns of a pre-debounced two-phase rotary encoder into a delay setpoint for an audio delay line. It checks the encoder only at a slow rate. A down-counter runs on the audio frame tick, and only the frame on which it expires takes a sample of the two encoder phases. Each check decides whether a new detent has arrived and, if so, which way the knob turned.

A detent is recognised on a falling level of phase A. A latch flag is set the first time A is seen low, so that A staying low over several samples counts only once. The flag clears again when A is seen high. The level of phase B at the detent gives the direction. The setpoint is 8 bits wide. It is also presented as the upper byte of a 16-bit desired delay in samples, whose lower byte is always zero. One detent therefore moves the delay by 256 samples, which is roughly 6 ms at common audio rates.

Top module: `enc_delay_setpoint`

## Requirements
- R1: After reset the setpoint and the 16-bit delay output are zero, the decimation counter holds 64 and the detent flag is clear.
- R2: The encoder is sampled only on every 64th frame tick counted from reset or from the previous sample. Encoder levels present on the other 63 ticks have no effect on the setpoint.
- R3: A sample with phase A high clears the detent flag, so that the next sample with A low counts as a new detent.
- R4: A sample with A low (0) while the flag is clear, with B low (0), is a clockwise detent and adds one to the setpoint.
- R5: A sample with A low while the flag is clear, with B high (1), is a counter-clockwise detent and subtracts one from the setpoint.
- R6: A sample with A low while the flag is already set leaves the setpoint unchanged, whatever the level of B.
- R7: The setpoint wraps modulo 256: decrementing 0 gives 255, and incrementing 255 gives 0.
- R8: The delay output equals the setpoint times 256. Its upper byte is the setpoint and its lower byte is zero.
- R9: Clock cycles without a frame tick advance neither the decimation counter nor the setpoint, even when the encoder levels change.
- R10: The setpoint changes on the clock edge that registers the 64th frame tick and is visible on the outputs in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_tick_i | input | 1 | One-cycle pulse per audio frame |
| enc_a_i | input | 1 | Encoder phase A level, already debounced |
| enc_b_i | input | 1 | Encoder phase B level, already debounced |
| setpoint_o | output | 8 | Delay setpoint in units of 256 samples |
| delay_o | output | 16 | Desired delay in samples: {setpoint, 8'h00} |

## Verification
The tests use single clockwise and counter-clockwise detents, each preceded by a release sample with A high. These show both directions and show that the flag is cleared. Phase A is held low across several samples to tell a latched edge from a new detent. Phase A is also held low for the 63 ticks that are not sampled and then raised on the sampled one. This separates a sampled input from an ignored one, and pins down the exact tick on which the setpoint moves. Runs of detents across 0 and 255 check the wrap in both directions. Toggling the encoder while no frame ticks arrive checks that the counter only advances on frames.

// File: rtl/enc_setpoint_pkg.sv
package enc_setpoint_pkg;
  localparam int unsigned DEF_DECIM = 64;
  localparam int unsigned DEF_SP_W  = 8;
  localparam int unsigned DEF_LOW_W = 8;

  typedef enum logic {
    DIR_CW  = 1'b0,
    DIR_CCW = 1'b1
  } dir_e;
endpackage

// File: rtl/frame_decimator.sv
module frame_decimator #(
  parameter int unsigned DECIM = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic sample_o
);
  localparam int unsigned CNT_W = $clog2(DECIM + 1);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(DECIM);
  localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  // expiry: the decrement that would reach zero
  assign sample_o = tick_i && (cnt_q == ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= RELOAD;
    else if (sample_o)  cnt_q <= RELOAD;
    else if (tick_i)    cnt_q <= cnt_q - ONE;
  end

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q >= ONE) && (cnt_q <= RELOAD)); // R2
  AST_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |=> (cnt_q == RELOAD)); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q)); // R9
endmodule

// File: rtl/detent_detector.sv
module detent_detector
  import enc_setpoint_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sample_i,
  input  logic enc_a_i,
  input  logic enc_b_i,
  output logic step_o,
  output dir_e dir_o
);
  logic seen_q;

  assign step_o = sample_i && !enc_a_i && !seen_q;
  assign dir_o  = enc_b_i ? DIR_CCW : DIR_CW;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 seen_q <= 1'b0;
    else if (sample_i && enc_a_i) seen_q <= 1'b0;
    else if (step_o)             seen_q <= 1'b1;
  end

  AST_LATCH_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |=> seen_q); // R6
  AST_NO_REPEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |-> !step_o); // R6
  AST_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_i && enc_a_i) |=> !seen_q); // R3
  AST_ONLY_SAMPLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_i |=> $stable(seen_q)); // R2
endmodule

// File: rtl/setpoint_accum.sv
module setpoint_accum
  import enc_setpoint_pkg::*;
#(
  parameter int unsigned SP_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            step_i,
  input  dir_e            dir_i,
  output logic [SP_W-1:0] sp_o
);
  localparam logic [SP_W-1:0] ONE = SP_W'(1);

  logic [SP_W-1:0] sp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sp_q <= '0;
    else if (step_i) sp_q <= (dir_i == DIR_CW) ? sp_q + ONE : sp_q - ONE;
  end

  assign sp_o = sp_q;

  AST_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && dir_i == DIR_CW) |=> (sp_q == $past(sp_q) + ONE)); // R4
  AST_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && dir_i == DIR_CCW) |=> (sp_q == $past(sp_q) - ONE)); // R5
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(sp_q)); // R6
endmodule

// File: rtl/enc_delay_setpoint.sv
module enc_delay_setpoint
  import enc_setpoint_pkg::*;
#(
  parameter int unsigned DECIM = DEF_DECIM,
  parameter int unsigned SP_W  = DEF_SP_W,
  parameter int unsigned LOW_W = DEF_LOW_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  frame_tick_i,
  input  logic                  enc_a_i,
  input  logic                  enc_b_i,
  output logic [SP_W-1:0]       setpoint_o,
  output logic [SP_W+LOW_W-1:0] delay_o
);
  logic sample;
  logic step;
  dir_e dir;

  frame_decimator #(.DECIM(DECIM)) u_decim (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (frame_tick_i),
    .sample_o (sample)
  );

  detent_detector u_detent (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sample_i (sample),
    .enc_a_i  (enc_a_i),
    .enc_b_i  (enc_b_i),
    .step_o   (step),
    .dir_o    (dir)
  );

  setpoint_accum #(.SP_W(SP_W)) u_accum (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (step),
    .dir_i  (dir),
    .sp_o   (setpoint_o)
  );

  assign delay_o = {setpoint_o, {LOW_W{1'b0}}};

  AST_STEP_NEEDS_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step |-> frame_tick_i); // R9
  AST_STEP_NEEDS_A_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step |-> !enc_a_i); // R4
endmodule

// File: tb/enc_delay_setpoint_tb.sv
module enc_delay_setpoint_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DECIM      = 64;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        frame_tick_i = 1'b0;
  logic        enc_a_i = 1'b1;
  logic        enc_b_i = 1'b0;
  logic [7:0]  setpoint_o;
  logic [15:0] delay_o;

  int checks = 0;
  int fails  = 0;
  int phase  = 0;       // ticks since last sample
  logic [7:0] exp_sp = 8'd0;
  logic       exp_seen = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  enc_delay_setpoint dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .frame_tick_i(frame_tick_i),
    .enc_a_i(enc_a_i), .enc_b_i(enc_b_i),
    .setpoint_o(setpoint_o), .delay_o(delay_o)
  );

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic send_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i); frame_tick_i = 1'b1;
      @(negedge clk_i); frame_tick_i = 1'b0;
      phase++;
    end
  endtask

  // hold a/b and tick up to and including the next sampled frame
  task automatic sample_with(input logic a, input logic b);
    @(negedge clk_i);
    enc_a_i = a; enc_b_i = b;
    send_ticks(DECIM - phase);
    phase = 0;
    if (a) exp_seen = 1'b0;
    else if (!exp_seen) begin
      exp_seen = 1'b1;
      exp_sp = b ? exp_sp - 8'd1 : exp_sp + 8'd1;
    end
  endtask

  task automatic t_reset;
    check({8'd0, setpoint_o}, 16'd0, "R1 setpoint");
    check(delay_o, 16'd0, "R1 delay");
  endtask

  task automatic t_cw;
    sample_with(1'b1, 1'b0);
    check({8'd0, setpoint_o}, {8'd0, exp_sp}, "R3 release no step");
    sample_with(1'b0, 1'b0);
    check({8'd0, setpoint_o}, 16'd1, "R4 cw detent");
    check(delay_o, 16'h0100, "R8 delay high byte");
  endtask

  task automatic t_held;
    sample_with(1'b0, 1'b0);
    check({8'd0, setpoint_o}, 16'd1, "R6 held low b low");
    sample_with(1'b0, 1'b1);
    check({8'd0, setpoint_o}, 16'd1, "R6 held low b high");
  endtask

  task automatic t_ccw_wrap;
    sample_with(1'b1, 1'b1);
    sample_with(1'b0, 1'b1);
    check({8'd0, setpoint_o}, 16'd0, "R5 ccw detent");
    sample_with(1'b1, 1'b1);
    sample_with(1'b0, 1'b1);
    check({8'd0, setpoint_o}, 16'd255, "R7 wrap down");
    check(delay_o, 16'hFF00, "R8 delay at 255");
    sample_with(1'b1, 1'b0);
    sample_with(1'b0, 1'b0);
    check({8'd0, setpoint_o}, 16'd0, "R7 wrap up");
    check({8'd0, setpoint_o}, {8'd0, exp_sp}, "R7 model");
  endtask

  task automatic t_decim;
    sample_with(1'b1, 1'b0);
    @(negedge clk_i); enc_a_i = 1'b0; enc_b_i = 1'b0;
    send_ticks(DECIM - 1);
    check({8'd0, setpoint_o}, 16'd0, "R2 unsampled ticks ignored");
    @(negedge clk_i); enc_a_i = 1'b1;
    send_ticks(1); phase = 0; exp_seen = 1'b0;
    check({8'd0, setpoint_o}, 16'd0, "R2 high on sampled tick");
    // low only on the sampled tick counts, and shows one cycle after its edge
    @(negedge clk_i); enc_a_i = 1'b1;
    send_ticks(DECIM - 1);
    @(negedge clk_i); enc_a_i = 1'b0; enc_b_i = 1'b0; frame_tick_i = 1'b1;
    @(negedge clk_i); frame_tick_i = 1'b0; phase = 0;
    exp_seen = 1'b1; exp_sp = exp_sp + 8'd1;
    check({8'd0, setpoint_o}, 16'd1, "R10 update after 64th tick");
  endtask

  task automatic t_no_tick;
    sample_with(1'b1, 1'b0);
    for (int i = 0; i < 300; i++) begin
      @(negedge clk_i); enc_a_i = ~enc_a_i; enc_b_i = i[1];
    end
    enc_a_i = 1'b1;
    check({8'd0, setpoint_o}, {8'd0, exp_sp}, "R9 no ticks no change");
    // counter must not have moved: next low counts exactly DECIM ticks later
    @(negedge clk_i); enc_a_i = 1'b0; enc_b_i = 1'b0;
    send_ticks(DECIM - 1);
    check({8'd0, setpoint_o}, {8'd0, exp_sp}, "R9 counter held");
    send_ticks(1); phase = 0;
    exp_seen = 1'b1; exp_sp = exp_sp + 8'd1;
    check({8'd0, setpoint_o}, {8'd0, exp_sp}, "R9 sample after idle");
  endtask

  task automatic t_multi;
    for (int i = 0; i < 3; i++) begin
      sample_with(1'b1, 1'b0);
      sample_with(1'b0, 1'b0);
    end
    check({8'd0, setpoint_o}, {8'd0, exp_sp}, "R4 three cw detents");
    check(delay_o, {exp_sp, 8'h00}, "R8 delay after cw run");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_cw();
    t_held();
    t_ccw_wrap();
    t_decim();
    t_no_tick();
    t_multi();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule